// File: doc/BRIEF.md
# Tag-Matching Reservation Station

This block is a small instruction buffer that sits in front of a single execution unit. Operands are read when an instruction is issued. A source that already has its value arrives with a ready flag and the value itself. A source still being produced arrives with the flag clear and a producer tag in the low bits of the same field. The block watches a result bus. Whenever a broadcast tag equals a pending source tag, it replaces that tag with the broadcast value. Once both sources of an entry hold values, the entry can go to the execution unit. There is at most one dispatch per cycle, and the oldest ready entry goes first.

Every entry is a three-state machine: SLOT_FREE, SLOT_WAIT and SLOT_READY.
- A write moves SLOT_FREE to SLOT_READY (fill-ready) when both sources are present.
- Otherwise a write moves SLOT_FREE to SLOT_WAIT (fill-wait).
- The last matching broadcast moves SLOT_WAIT to SLOT_READY (wake).
- An accepted dispatch moves SLOT_READY back to SLOT_FREE (drain).

The dispatch picker is a two-state machine.
- In PICK_OPEN it chooses the oldest ready entry each cycle.
- A stall moves PICK_OPEN to PICK_HOLD (stall): the unit refused the offer, and the picker locks that entry.
- Acceptance moves PICK_HOLD back to PICK_OPEN (release).

Entry order is kept as an age value per entry. The age counts the younger occupied entries.

A build parameter chooses how an empty station behaves. In the default mode every instruction stays at least one cycle. In bypass mode, a ready instruction offered to an empty station is presented to the execution unit in the same cycle.

Top module: `tag_match_rs`

## Requirements
- R1: After reset the station is empty, `iss_full` is 0 and `dsp_valid` is 0.
- R2: An issued source with its ready flag set is stored as the value given. That value is the one later presented on `dsp_s1`/`dsp_s2`, with `dsp_op` and `dsp_dst` unchanged.
- R3: A source issued with its ready flag clear is held as a tag, which is bits [TW-1:0] of the source field. When `res_valid` is high and `res_tag` equals that tag, the entry takes `res_data` as the source value.
- R4: A broadcast in the same cycle as the issue is applied to the instruction being issued.
- R5: An entry is offered for dispatch only when both of its sources hold values. A broadcast whose tag matches neither pending source leaves it waiting.
- R6: When several entries are ready, the one issued earliest is presented first.
- R7: `iss_full` is 1 exactly when all DEPTH entries are occupied. An issue attempted while full is dropped and changes no entry.
- R8: While `dsp_valid` is 1 and `dsp_ready` is 0, the same instruction stays on the dispatch outputs. This holds even if an older entry becomes ready in the meantime. It leaves the station only in a cycle with both signals high.
- R9: With BYPASS=1 and the station empty, an instruction whose sources are ready (including through R4) is presented in its issue cycle. If `dsp_ready` is 1 it is not stored. Otherwise it is stored and presented on the following cycles.
- R10: With BYPASS=0 an instruction is presented no earlier than the cycle after its issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_full | output | 1 | No free entry; issue is refused |
| iss_op | input | OPW | Opcode of the issued instruction |
| iss_s1_rdy | input | 1 | Source 1 field holds a value (1) or a tag (0) |
| iss_s1 | input | DW | Source 1 value, or tag in bits [TW-1:0] |
| iss_s2_rdy | input | 1 | Source 2 field holds a value (1) or a tag (0) |
| iss_s2 | input | DW | Source 2 value, or tag in bits [TW-1:0] |
| iss_dst | input | TW | Destination register identifier |
| res_valid | input | 1 | Result bus broadcast valid |
| res_tag | input | TW | Register identifier of the broadcast |
| res_data | input | DW | Broadcast value |
| dsp_valid | output | 1 | Instruction offered to the execution unit |
| dsp_ready | input | 1 | Execution unit accepts the offer |
| dsp_op | output | OPW | Dispatched opcode |
| dsp_s1 | output | DW | Dispatched source 1 value |
| dsp_s2 | output | DW | Dispatched source 2 value |
| dsp_dst | output | TW | Dispatched destination identifier |

## Verification
The bench builds two copies side by side and drives both with the same stimulus.
- One copy uses DEPTH=4 and BYPASS=0. It covers ordering across four ages and the one-cycle minimum stay.
- The other uses DEPTH=2 and BYPASS=1. Its small depth makes the station fill often, so refused issues and same-cycle bypass, both with and without a stall, come up many times in random traffic.

With TW=3 the random result tags hit pending sources often enough to exercise wake-up on both sources, including in the issue cycle.

// File: rtl/rs_pkg.sv
package rs_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_WAIT  = 2'd1,
        SLOT_READY = 2'd2
    } slot_state_t;

    typedef enum logic {
        PICK_OPEN = 1'b0,
        PICK_HOLD = 1'b1
    } pick_state_t;
endpackage

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int OPW   = 4,
    parameter int DW    = 16,
    parameter int TW    = 3,
    parameter int AW    = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [OPW-1:0] wr_op,
    input  logic           wr_v1,
    input  logic [DW-1:0]  wr_s1,
    input  logic           wr_v2,
    input  logic [DW-1:0]  wr_s2,
    input  logic [TW-1:0]  wr_dst,
    input  logic           res_valid,
    input  logic [TW-1:0]  res_tag,
    input  logic [DW-1:0]  res_data,
    input  logic           issue_in,
    input  logic           deq_fire,
    input  logic           deq_me,
    input  logic [AW-1:0]  deq_age,
    output logic           occupied,
    output logic           ready,
    output logic [AW-1:0]  age,
    output logic [OPW-1:0] op,
    output logic [DW-1:0]  s1,
    output logic [DW-1:0]  s2,
    output logic [TW-1:0]  dst
);
    slot_state_t state, state_d;
    logic v1, v2;
    logic hit1, hit2, load, dec;

    assign load = (state == SLOT_FREE) && wr_en;
    assign hit1 = (state == SLOT_WAIT) && !v1 && res_valid && (res_tag == s1[TW-1:0]);
    assign hit2 = (state == SLOT_WAIT) && !v2 && res_valid && (res_tag == s2[TW-1:0]);
    assign dec  = deq_fire && !deq_me && (deq_age < age);

    assign occupied = (state != SLOT_FREE);
    assign ready    = (state == SLOT_READY);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SLOT_FREE;
        else        state <= state_d;
    end

    always_comb begin
        state_d = state;
        unique case (state)
            SLOT_FREE:  if (wr_en) state_d = (wr_v1 && wr_v2) ? SLOT_READY : SLOT_WAIT;
            SLOT_WAIT:  if ((v1 || hit1) && (v2 || hit2)) state_d = SLOT_READY;
            SLOT_READY: if (deq_me) state_d = SLOT_FREE;
            default:    state_d = SLOT_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0; v2 <= 1'b0;
            s1 <= '0;   s2 <= '0;
            op <= '0;   dst <= '0;
        end else if (load) begin
            v1 <= wr_v1; s1 <= wr_s1;
            v2 <= wr_v2; s2 <= wr_s2;
            op <= wr_op; dst <= wr_dst;
        end else begin
            if (hit1) begin v1 <= 1'b1; s1 <= res_data; end
            if (hit2) begin v2 <= 1'b1; s2 <= res_data; end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) age <= '0;
        else if (load) age <= '0;
        else if (occupied) begin
            unique case ({issue_in, dec})
                2'b10:   age <= age + AW'(1);
                2'b01:   age <= age - AW'(1);
                default: age <= age;
            endcase
        end
    end

    assert_wake_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SLOT_WAIT && !v1 && res_valid && res_tag == s1[TW-1:0])
        |=> (v1 && s1 == $past(res_data)));

    assert_ready_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SLOT_READY) |-> (v1 && v2));

    assert_age_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        occupied |-> (int'(age) < DEPTH));
endmodule

// File: rtl/rs_alloc.sv
module rs_alloc #(
    parameter int DEPTH = 4,
    parameter int IW    = 2
) (
    input  logic [DEPTH-1:0] occ,
    output logic [IW-1:0]    free_idx,
    output logic             full
);
    always_comb begin
        free_idx = '0;
        full     = 1'b1;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!occ[i]) begin
                free_idx = IW'(i);
                full     = 1'b0;
            end
        end
    end
endmodule

// File: rtl/rs_pick.sv
module rs_pick
    import rs_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int AW    = 2,
    parameter int IW    = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [DEPTH-1:0]       rdy,
    input  logic [DEPTH-1:0][AW-1:0] ages,
    input  logic                   dsp_ready,
    output logic                   pick_valid,
    output logic [IW-1:0]          pick_idx
);
    pick_state_t state, state_d;
    logic [IW-1:0] held_idx, best_idx;
    logic [AW-1:0] best_age;
    logic          best_ok;

    always_comb begin
        best_ok  = 1'b0;
        best_idx = '0;
        best_age = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rdy[i] && (!best_ok || ages[i] > best_age)) begin
                best_ok  = 1'b1;
                best_idx = IW'(i);
                best_age = ages[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= PICK_OPEN;
        else        state <= state_d;
    end

    always_comb begin
        state_d = state;
        unique case (state)
            PICK_OPEN: if (best_ok && !dsp_ready) state_d = PICK_HOLD;
            PICK_HOLD: if (dsp_ready) state_d = PICK_OPEN;
            default:   state_d = PICK_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                   held_idx <= '0;
        else if (state == PICK_OPEN)  held_idx <= best_idx;
    end

    always_comb begin
        unique case (state)
            PICK_HOLD: begin pick_valid = 1'b1;    pick_idx = held_idx; end
            default:   begin pick_valid = best_ok; pick_idx = best_idx; end
        endcase
    end

    logic older_ready;
    always_comb begin
        older_ready = 1'b0;
        for (int j = 0; j < DEPTH; j++)
            if (rdy[j] && ages[j] > ages[pick_idx]) older_ready = 1'b1;
    end

    assert_pick_oldest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PICK_OPEN && pick_valid) |-> !older_ready);

    assert_hold_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PICK_HOLD) |-> rdy[held_idx]);
endmodule

// File: rtl/tag_match_rs.sv
module tag_match_rs #(
    parameter int DEPTH  = 4,
    parameter int OPW    = 4,
    parameter int DW     = 16,
    parameter int TW     = 3,
    parameter int BYPASS = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           iss_valid,
    output logic           iss_full,
    input  logic [OPW-1:0] iss_op,
    input  logic           iss_s1_rdy,
    input  logic [DW-1:0]  iss_s1,
    input  logic           iss_s2_rdy,
    input  logic [DW-1:0]  iss_s2,
    input  logic [TW-1:0]  iss_dst,
    input  logic           res_valid,
    input  logic [TW-1:0]  res_tag,
    input  logic [DW-1:0]  res_data,
    output logic           dsp_valid,
    input  logic           dsp_ready,
    output logic [OPW-1:0] dsp_op,
    output logic [DW-1:0]  dsp_s1,
    output logic [DW-1:0]  dsp_s2,
    output logic [TW-1:0]  dsp_dst
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int AW = IW;

    logic [DEPTH-1:0]         occ, rdy;
    logic [DEPTH-1:0][AW-1:0] age_a;
    logic [OPW-1:0] op_a  [DEPTH];
    logic [DW-1:0]  s1_a  [DEPTH];
    logic [DW-1:0]  s2_a  [DEPTH];
    logic [TW-1:0]  dst_a [DEPTH];

    logic          fwd1_v, fwd2_v, byp, store, deq_fire, pick_valid, empty;
    logic [DW-1:0] fwd1, fwd2;
    logic [IW-1:0] free_idx, pick_idx;

    always_comb begin
        fwd1_v = iss_s1_rdy;
        fwd1   = iss_s1;
        if (!iss_s1_rdy && res_valid && res_tag == iss_s1[TW-1:0]) begin
            fwd1_v = 1'b1;
            fwd1   = res_data;
        end
        fwd2_v = iss_s2_rdy;
        fwd2   = iss_s2;
        if (!iss_s2_rdy && res_valid && res_tag == iss_s2[TW-1:0]) begin
            fwd2_v = 1'b1;
            fwd2   = res_data;
        end
    end

    assign empty = ~|occ;

    generate
        if (BYPASS != 0) begin : g_bypass
            assign byp = empty && iss_valid && fwd1_v && fwd2_v;
        end else begin : g_stay
            assign byp = 1'b0;
        end
    endgenerate

    assign store    = iss_valid && !iss_full && !(byp && dsp_ready);
    assign deq_fire = pick_valid && dsp_ready && !byp;

    rs_alloc #(.DEPTH(DEPTH), .IW(IW)) u_alloc (
        .occ(occ), .free_idx(free_idx), .full(iss_full)
    );

    rs_pick #(.DEPTH(DEPTH), .AW(AW), .IW(IW)) u_pick (
        .clk(clk), .rst_n(rst_n), .rdy(rdy), .ages(age_a),
        .dsp_ready(dsp_ready), .pick_valid(pick_valid), .pick_idx(pick_idx)
    );

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            rs_slot #(.DEPTH(DEPTH), .OPW(OPW), .DW(DW), .TW(TW), .AW(AW)) u_slot (
                .clk(clk), .rst_n(rst_n),
                .wr_en(store && (free_idx == IW'(g))),
                .wr_op(iss_op), .wr_v1(fwd1_v), .wr_s1(fwd1),
                .wr_v2(fwd2_v), .wr_s2(fwd2), .wr_dst(iss_dst),
                .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
                .issue_in(store), .deq_fire(deq_fire),
                .deq_me(deq_fire && (pick_idx == IW'(g))),
                .deq_age(age_a[pick_idx]),
                .occupied(occ[g]), .ready(rdy[g]), .age(age_a[g]),
                .op(op_a[g]), .s1(s1_a[g]), .s2(s2_a[g]), .dst(dst_a[g])
            );
        end
    endgenerate

    always_comb begin
        if (byp) begin
            dsp_valid = 1'b1;
            dsp_op    = iss_op;
            dsp_s1    = fwd1;
            dsp_s2    = fwd2;
            dsp_dst   = iss_dst;
        end else begin
            dsp_valid = pick_valid;
            dsp_op    = op_a[pick_idx];
            dsp_s1    = s1_a[pick_idx];
            dsp_s2    = s2_a[pick_idx];
            dsp_dst   = dst_a[pick_idx];
        end
    end

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_valid && !dsp_ready) |=> (dsp_valid && $stable(dsp_op) && $stable(dsp_s1)
                                       && $stable(dsp_s2) && $stable(dsp_dst)));

    assert_full_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_full && iss_valid) |=> ($countones(occ) <= $past($countones(occ))));

    generate
        if (BYPASS == 0) begin : g_stay_chk
            assert_min_stay_R10: assert property (@(posedge clk) disable iff (!rst_n)
                empty |-> !dsp_valid);
        end
    endgenerate
endmodule

// File: tb/tag_match_rs_test.sv
module tag_match_rs_test;
    localparam int OPW = 4, DW = 16, TW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    always #5 clk = ~clk;

    logic           iss_valid = 0, iss_s1_rdy = 0, iss_s2_rdy = 0, res_valid = 0, dsp_ready = 0;
    logic [OPW-1:0] iss_op = 0;
    logic [DW-1:0]  iss_s1 = 0, iss_s2 = 0, res_data = 0;
    logic [TW-1:0]  iss_dst = 0, res_tag = 0;

    logic           o_full [2], o_dv [2];
    logic [OPW-1:0] o_op [2];
    logic [DW-1:0]  o_s1 [2], o_s2 [2];
    logic [TW-1:0]  o_dst [2];

    tag_match_rs #(.DEPTH(4), .OPW(OPW), .DW(DW), .TW(TW), .BYPASS(0)) uut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_full(o_full[0]),
        .iss_op(iss_op), .iss_s1_rdy(iss_s1_rdy), .iss_s1(iss_s1),
        .iss_s2_rdy(iss_s2_rdy), .iss_s2(iss_s2), .iss_dst(iss_dst),
        .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
        .dsp_valid(o_dv[0]), .dsp_ready(dsp_ready), .dsp_op(o_op[0]),
        .dsp_s1(o_s1[0]), .dsp_s2(o_s2[0]), .dsp_dst(o_dst[0]));

    tag_match_rs #(.DEPTH(2), .OPW(OPW), .DW(DW), .TW(TW), .BYPASS(1)) uut_byp (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_full(o_full[1]),
        .iss_op(iss_op), .iss_s1_rdy(iss_s1_rdy), .iss_s1(iss_s1),
        .iss_s2_rdy(iss_s2_rdy), .iss_s2(iss_s2), .iss_dst(iss_dst),
        .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
        .dsp_valid(o_dv[1]), .dsp_ready(dsp_ready), .dsp_op(o_op[1]),
        .dsp_s1(o_s1[1]), .dsp_s2(o_s2[1]), .dsp_dst(o_dst[1]));

    int errors = 0, checks = 0, seqc = 0;
    bit done = 0;
    string cur_req = "R1";

    int  mdepth [2] = '{4, 2};
    bit  mbyp   [2] = '{1'b0, 1'b1};
    bit  mv [2][4], m1v [2][4], m2v [2][4];
    logic [DW-1:0]  m1 [2][4], m2 [2][4];
    logic [OPW-1:0] mop [2][4];
    logic [TW-1:0]  mdst [2][4];
    int  mseq [2][4];
    bit  mhold [2];
    int  mhe [2];

    function automatic logic [DW-1:0] fwd_val(logic rdy, logic [DW-1:0] f);
        if (!rdy && res_valid && res_tag == f[TW-1:0]) return res_data;
        return f;
    endfunction

    function automatic bit fwd_ok(logic rdy, logic [DW-1:0] f);
        return rdy || (res_valid && res_tag == f[TW-1:0]);
    endfunction

    task automatic model_cycle(input int k);
        int n = 0, ee = -1, best = 0;
        bit ev = 0, eb = 0, efull, fire, bad;
        logic [OPW-1:0] xop; logic [DW-1:0] x1, x2; logic [TW-1:0] xd;
        for (int e = 0; e < mdepth[k]; e++) if (mv[k][e]) n++;
        efull = (n == mdepth[k]);
        if (mhold[k]) ee = mhe[k];
        else
            for (int e = 0; e < mdepth[k]; e++)
                if (mv[k][e] && m1v[k][e] && m2v[k][e] && (ee < 0 || mseq[k][e] < best)) begin
                    ee = e; best = mseq[k][e];
                end
        if (ee >= 0) begin
            ev = 1; xop = mop[k][ee]; x1 = m1[k][ee]; x2 = m2[k][ee]; xd = mdst[k][ee];
        end else if (mbyp[k] && n == 0 && iss_valid && fwd_ok(iss_s1_rdy, iss_s1)
                     && fwd_ok(iss_s2_rdy, iss_s2)) begin
            ev = 1; eb = 1; xop = iss_op; xd = iss_dst;
            x1 = fwd_val(iss_s1_rdy, iss_s1); x2 = fwd_val(iss_s2_rdy, iss_s2);
        end
        checks++;
        bad = (o_full[k] !== efull) || (o_dv[k] !== ev);
        if (ev && !bad)
            bad = (o_op[k] !== xop) || (o_s1[k] !== x1) || (o_s2[k] !== x2) || (o_dst[k] !== xd);
        if (bad) begin
            errors++;
            $display("FAIL %s inst%0d t=%0t: full=%0b dv=%0b op=%h s1=%h s2=%h dst=%h exp full=%0b dv=%0b op=%h s1=%h s2=%h dst=%h",
                     cur_req, k, $time, o_full[k], o_dv[k], o_op[k], o_s1[k], o_s2[k], o_dst[k],
                     efull, ev, xop, x1, x2, xd);
        end
        fire = ev && dsp_ready;
        for (int e = 0; e < mdepth[k]; e++) if (mv[k][e] && res_valid) begin
            if (!m1v[k][e] && res_tag == m1[k][e][TW-1:0]) begin m1v[k][e] = 1; m1[k][e] = res_data; end
            if (!m2v[k][e] && res_tag == m2[k][e][TW-1:0]) begin m2v[k][e] = 1; m2[k][e] = res_data; end
        end
        if (fire && !eb) mv[k][ee] = 0;
        mhold[k] = ev && !dsp_ready && !eb;
        mhe[k]   = ee;
        if (iss_valid && !efull && !(eb && fire)) begin
            for (int e = 0; e < mdepth[k]; e++) if (!mv[k][e]) begin
                mv[k][e] = 1; mop[k][e] = iss_op; mdst[k][e] = iss_dst; mseq[k][e] = seqc;
                m1v[k][e] = fwd_ok(iss_s1_rdy, iss_s1); m1[k][e] = fwd_val(iss_s1_rdy, iss_s1);
                m2v[k][e] = fwd_ok(iss_s2_rdy, iss_s2); m2[k][e] = fwd_val(iss_s2_rdy, iss_s2);
                break;
            end
        end
    endtask

    task automatic tick();
        #1;
        model_cycle(0);
        model_cycle(1);
        seqc++;
        @(negedge clk);
    endtask

    task automatic idle();
        iss_valid = 0; res_valid = 0;
    endtask

    task automatic put(input logic [OPW-1:0] op, input logic r1, input logic [DW-1:0] a,
                       input logic r2, input logic [DW-1:0] b, input logic [TW-1:0] d);
        iss_valid = 1; iss_op = op; iss_s1_rdy = r1; iss_s1 = a;
        iss_s2_rdy = r2; iss_s2 = b; iss_dst = d;
    endtask

    task automatic bcast(input logic [TW-1:0] t, input logic [DW-1:0] v);
        res_valid = 1; res_tag = t; res_data = v;
    endtask

    task automatic drain();
        idle(); dsp_ready = 1;
        for (int i = 0; i < 12; i++) begin
            bcast(TW'(i), DW'(16'h0D00 + i)); tick();
        end
        idle(); tick(); tick();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1; errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20251));
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        for (int k = 0; k < 2; k++) begin
            checks++;
            if (o_dv[k] !== 1'b0 || o_full[k] !== 1'b0) begin
                errors++;
                $display("FAIL R1 inst%0d: dv=%0b full=%0b exp dv=0 full=0", k, o_dv[k], o_full[k]);
            end
        end
        @(negedge clk);
        idle(); tick();

        cur_req = "R10"; dsp_ready = 1;           // also R2: values pass through
        put(4'h3, 1, 16'h1234, 1, 16'h5678, 3'd2); tick();
        idle(); tick(); tick();

        cur_req = "R9"; dsp_ready = 0;
        put(4'h5, 1, 16'hAAAA, 1, 16'h5555, 3'd1); tick();
        idle(); tick(); tick();
        dsp_ready = 1; tick(); tick();
        put(4'h6, 0, 16'h0004, 1, 16'h0101, 3'd3); bcast(3'd4, 16'hBEEF); tick();
        idle(); tick(); tick();

        cur_req = "R3";
        put(4'h7, 0, 16'h0005, 1, 16'h2222, 3'd6); tick();
        idle(); tick(); tick(); tick();
        bcast(3'd5, 16'hCAFE); tick();
        idle(); tick(); tick();

        cur_req = "R4";
        put(4'h8, 1, 16'h3333, 0, 16'h0002, 3'd0); bcast(3'd2, 16'hF00D); tick();
        idle(); tick(); tick();

        cur_req = "R5";
        put(4'h9, 0, 16'h0003, 0, 16'h0004, 3'd5); tick();
        idle(); bcast(3'd3, 16'h1111); tick();
        bcast(3'd6, 16'h6666); tick();
        idle(); tick();
        bcast(3'd4, 16'h4444); tick();
        idle(); tick(); tick();

        cur_req = "R6"; dsp_ready = 0;
        put(4'hA, 1, 16'h000A, 1, 16'h00A0, 3'd1); tick();
        put(4'hB, 1, 16'h000B, 1, 16'h00B0, 3'd2); tick();
        put(4'hC, 1, 16'h000C, 1, 16'h00C0, 3'd3); tick();
        idle(); dsp_ready = 1;
        for (int i = 0; i < 5; i++) tick();

        cur_req = "R7";
        for (int i = 0; i < 6; i++) begin
            put(4'(i), 0, 16'h0007, 1, DW'(i), 3'd4); tick();
        end
        idle(); bcast(3'd7, 16'h7777); tick();
        idle();
        for (int i = 0; i < 6; i++) tick();

        cur_req = "R8"; dsp_ready = 0;
        put(4'hD, 0, 16'h0001, 1, 16'h0D0D, 3'd2); tick();
        put(4'hE, 1, 16'h0E0E, 1, 16'hE0E0, 3'd3); tick();
        idle(); tick();
        bcast(3'd1, 16'h1001); tick();
        idle(); tick(); tick();
        dsp_ready = 1; tick(); tick(); tick();
        drain();

        cur_req = "R6";
        for (int i = 0; i < 4000; i++) begin
            iss_valid  = ($urandom % 3) != 0;
            iss_op     = OPW'($urandom);
            iss_s1_rdy = $urandom % 2;  iss_s1 = DW'($urandom);
            iss_s2_rdy = $urandom % 2;  iss_s2 = DW'($urandom);
            iss_dst    = TW'($urandom);
            res_valid  = $urandom % 2;
            res_tag    = TW'($urandom); res_data = DW'($urandom);
            dsp_ready  = ($urandom % 10) < 7;
            tick();
        end
        drain();

        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule